// File: doc/BRIEF.md
# Timer Channel Control and Event Register Bank

This block holds the shared control and status state of a six-channel timer unit and presents it on a simple 32-bit register bus. It keeps four state words: channel run enables (plus the free-running system counter enable), channel stop bits (plus the watchdog clock stop), compare event flags, and interrupt masks. Each word has one readable address and two write-only companion addresses. Writing ones to the first companion raises those bits. Writing ones to the second lowers them. Zero bits written to either leave the state alone, so software never has to read, modify and write back.

The channel counters sit outside this block. They report a full-compare match and a half-compare match as one-cycle pulses, and each pulse latches the matching flag bit. Each channel has one interrupt line. The line is high while that channel has a latched flag whose mask bit is clear. The enable and stop words also drive the counters directly through dedicated outputs.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset the enable word reads 0x0000_0000, the stop word reads 0x0001_003F, the flag word reads 0x0000_0000 and the mask word reads 0x003F_003F.
- R2: A read (sel=1, wr=0) returns the enable word at offset 0x10, the stop word at 0x1C, the flag word at 0x20 and the mask word at 0x30. Every other offset, including the set and clear companions, reads zero. bus_rdata is zero when no read is in progress.
- R3: A write to a set companion (enable 0x14, stop 0x2C, flag 0x24, mask 0x34) raises exactly the bits written as one, from the next cycle onward. Bits written as zero keep their value.
- R4: A write to a clear companion (enable 0x18, stop 0x3C, flag 0x28, mask 0x38) lowers exactly the bits written as one, from the next cycle onward. Bits written as zero keep their value.
- R5: The implemented bits are as follows. Enable: bits 5:0 are channels 0 to 5 and bit 15 is the system counter. Stop: bits 5:0 are the channels and bit 16 is the watchdog. Flag and mask: bits 5:0 are the full-match bits and bits 21:16 are the half-match bits of channels 0 to 5. All other bits read zero and ignore writes.
- R6: A pulse on full_evt[n] or half_evt[n] latches flag bit n or 16+n at that clock edge. The bit reads set from the next cycle and stays set until software clears it.
- R7: When a software clear and an event pulse hit the same flag bit in the same cycle, the bit ends up set.
- R8: irq[n] is high exactly when (flag bit n set and mask bit n clear) or (flag bit 16+n set and mask bit 16+n clear).
- R9: chan_en mirrors enable bits 5:0 and os_cnt_en mirrors enable bit 15. chan_stop mirrors stop bits 5:0 and wdt_stop mirrors stop bit 16.
- R10: A write cycle with bus_sel low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| full_evt | input | 6 | Per-channel full-compare pulse |
| half_evt | input | 6 | Per-channel half-compare pulse |
| irq | output | 6 | Per-channel interrupt request |
| chan_en | output | 6 | Channel counter enables |
| os_cnt_en | output | 1 | Free-running system counter enable |
| chan_stop | output | 6 | Channel clock stop |
| wdt_stop | output | 1 | Watchdog clock stop |

## Verification
The assertions check four things on every cycle. Only one set or clear strobe fires per access. An event pulse always leaves its flag set, even under a simultaneous clear. A set or clear write takes effect on the next cycle. The interrupt lines stay low when every mask bit is set or no flag is set. Only the bench's scenarios can show the rest: the exact offset map, the zero read-back of the companion and unused offsets, the reset values, the fact that unimplemented bit positions ignore all-ones writes, and the way irq follows mixed full and half flags under partial masking. A behavioural model compares every output on every cycle through both directed and pseudo-random access streams.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int NREG = 4;
  typedef enum int {RI_EN = 0, RI_STOP = 1, RI_FLAG = 2, RI_MASK = 3} reg_idx_e;

  // Offsets are decoded by software drivers, so they stay fixed.
  function automatic logic [7:0] rd_ofs(input int i);
    case (i)
      RI_EN:   return 8'h10;
      RI_STOP: return 8'h1C;
      RI_FLAG: return 8'h20;
      default: return 8'h30;
    endcase
  endfunction

  function automatic logic [7:0] set_ofs(input int i);
    case (i)
      RI_EN:   return 8'h14;
      RI_STOP: return 8'h2C;
      RI_FLAG: return 8'h24;
      default: return 8'h34;
    endcase
  endfunction

  function automatic logic [7:0] clr_ofs(input int i);
    case (i)
      RI_EN:   return 8'h18;
      RI_STOP: return 8'h3C;
      RI_FLAG: return 8'h28;
      default: return 8'h38;
    endcase
  endfunction
endpackage

// File: rtl/tcb_rst_sync.sv
module tcb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= 2'b00;
    else        stg <= {stg[0], 1'b1};
  end

  assign srst_n = stg[1];
endmodule

// File: rtl/tcb_decode.sv
module tcb_decode
  import tcb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NREG-1:0]   set_stb,
  output logic [NREG-1:0]   clr_stb,
  output logic [NREG-1:0]   rd_hit
);
  logic wr_go, rd_go;

  assign wr_go = bus_sel & bus_wr;
  assign rd_go = bus_sel & ~bus_wr;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign set_stb[g] = wr_go && (bus_addr == ADDR_W'(set_ofs(g)));
    assign clr_stb[g] = wr_go && (bus_addr == ADDR_W'(clr_ofs(g)));
    assign rd_hit[g]  = rd_go && (bus_addr == ADDR_W'(rd_ofs(g)));
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_stb, clr_stb, rd_hit}));

  // R10
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> ({set_stb, clr_stb, rd_hit} == '0));
endmodule

// File: rtl/tcb_w1sc_reg.sv
module tcb_w1sc_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits, clr_bits, hw_bits, q_nxt;
  logic         upd;

  always_comb begin
    set_bits = set_stb ? (wdata & IMPL) : '0;
    clr_bits = clr_stb ? (wdata & IMPL) : '0;
    hw_bits  = hw_set & IMPL;
    // hardware events are ORed last so they override a same-cycle clear
    q_nxt    = ((q | set_bits) & ~clr_bits) | hw_bits;
    upd      = set_stb | clr_stb | (|hw_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RSTV & IMPL;
    else if (upd) q <= q_nxt;
  end

  // R3
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(set_bits)) == $past(set_bits)));

  // R4
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & $past(clr_bits & ~hw_bits)) == '0));

  // R7
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_bits) |=> ((q & $past(hw_bits)) == $past(hw_bits)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb && hw_set == '0) |=> $stable(q));
endmodule

// File: rtl/tcb_irq_merge.sv
module tcb_irq_merge #(
  parameter int DATA_W   = 32,
  parameter int NCH      = 6,
  parameter int HALF_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] flags,
  input  logic [DATA_W-1:0] masks,
  output logic [NCH-1:0]    irq
);
  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign irq[n] = (flags[n] & ~masks[n]) |
                    (flags[HALF_LSB+n] & ~masks[HALF_LSB+n]);
  end

  // R8
  no_flag_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (irq == '0));
endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
  import tcb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NCH      = 6,
  parameter int HALF_LSB = 16,
  parameter int OS_BIT   = 15,
  parameter int WDT_BIT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    full_evt,
  input  logic [NCH-1:0]    half_evt,
  output logic [NCH-1:0]    irq,
  output logic [NCH-1:0]    chan_en,
  output logic              os_cnt_en,
  output logic [NCH-1:0]    chan_stop,
  output logic              wdt_stop
);
  localparam logic [DATA_W-1:0] CH_BITS  = DATA_W'((64'd1 << NCH) - 64'd1);
  localparam logic [DATA_W-1:0] EN_IMPL  = CH_BITS | (DATA_W'(1) << OS_BIT);
  localparam logic [DATA_W-1:0] ST_IMPL  = CH_BITS | (DATA_W'(1) << WDT_BIT);
  localparam logic [DATA_W-1:0] EV_IMPL  = CH_BITS | (CH_BITS << HALF_LSB);
  localparam logic [DATA_W-1:0] IMPL_V [NREG] = '{EN_IMPL, ST_IMPL, EV_IMPL, EV_IMPL};
  localparam logic [DATA_W-1:0] RST_V  [NREG] = '{'0, ST_IMPL, '0, EV_IMPL};

  logic              srst_n;
  logic [NREG-1:0]   set_stb, clr_stb, rd_hit;
  logic [DATA_W-1:0] hw_v [NREG];
  logic [DATA_W-1:0] q_v  [NREG];

  tcb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  tcb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(srst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .set_stb(set_stb), .clr_stb(clr_stb), .rd_hit(rd_hit)
  );

  assign hw_v[RI_EN]   = '0;
  assign hw_v[RI_STOP] = '0;
  assign hw_v[RI_FLAG] = (DATA_W'(half_evt) << HALF_LSB) | DATA_W'(full_evt);
  assign hw_v[RI_MASK] = '0;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    tcb_w1sc_reg #(.W(DATA_W), .IMPL(IMPL_V[g]), .RSTV(RST_V[g])) u_reg (
      .clk(clk), .rst_n(srst_n), .set_stb(set_stb[g]), .clr_stb(clr_stb[g]),
      .wdata(bus_wdata), .hw_set(hw_v[g]), .q(q_v[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_hit[i]) bus_rdata = bus_rdata | q_v[i];
  end

  tcb_irq_merge #(.DATA_W(DATA_W), .NCH(NCH), .HALF_LSB(HALF_LSB)) u_irq (
    .clk(clk), .rst_n(srst_n), .flags(q_v[RI_FLAG]), .masks(q_v[RI_MASK]), .irq(irq)
  );

  assign chan_en   = q_v[RI_EN][NCH-1:0];
  assign os_cnt_en = q_v[RI_EN][OS_BIT];
  assign chan_stop = q_v[RI_STOP][NCH-1:0];
  assign wdt_stop  = q_v[RI_STOP][WDT_BIT];

  // R8
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((q_v[RI_MASK] & EV_IMPL) == EV_IMPL) |-> (irq == '0));

  // R6
  evt_latch_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (full_evt != '0) |=> ((q_v[RI_FLAG][NCH-1:0] & $past(full_evt)) == $past(full_evt)));
endmodule

// File: tb/sim_tmr_ctl_bank.sv
`timescale 1ns/1ps
module sim_tmr_ctl_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [5:0]  full_evt, half_evt, irq, chan_en, chan_stop;
  logic        os_cnt_en, wdt_stop;

  always #10 clk = ~clk;

  tmr_ctl_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .full_evt(full_evt), .half_evt(half_evt), .irq(irq), .chan_en(chan_en),
    .os_cnt_en(os_cnt_en), .chan_stop(chan_stop), .wdt_stop(wdt_stop)
  );

  // behavioural reference state
  logic [31:0] m_en, m_st, m_fl, m_mk;
  int vectors = 0, miscompares = 0;
  string cur_tag = "R1";
  bit done = 0;

  localparam logic [31:0] EN_IM = 32'h0000_803F;
  localparam logic [31:0] ST_IM = 32'h0001_003F;
  localparam logic [31:0] EV_IM = 32'h003F_003F;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic s, input logic w, input logic [7:0] a);
    if (!s || w) return 32'h0;
    case (a)
      8'h10:   return m_en;
      8'h1C:   return m_st;
      8'h20:   return m_fl;
      8'h30:   return m_mk;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [5:0] m_irq();
    logic [5:0] r;
    for (int n = 0; n < 6; n++)
      r[n] = (m_fl[n] & ~m_mk[n]) | (m_fl[16+n] & ~m_mk[16+n]);
    return r;
  endfunction

  task automatic step(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic [5:0] fe, input logic [5:0] he);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    full_evt = fe; half_evt = he;
    #2;
    chk(cur_tag, "rdata", bus_rdata, m_read(s, w, a));
    chk("R8", "irq", {26'h0, irq}, {26'h0, m_irq()});
    chk("R9", "enables", {25'h0, os_cnt_en, chan_en}, {25'h0, m_en[15], m_en[5:0]});
    chk("R9", "stops", {25'h0, wdt_stop, chan_stop}, {25'h0, m_st[16], m_st[5:0]});
    @(posedge clk);
    if (s && w) begin
      case (a)
        8'h14: m_en = m_en | (d & EN_IM);
        8'h18: m_en = m_en & ~d;
        8'h2C: m_st = m_st | (d & ST_IM);
        8'h3C: m_st = m_st & ~d;
        8'h24: m_fl = m_fl | (d & EV_IM);
        8'h28: m_fl = m_fl & ~d;
        8'h34: m_mk = m_mk | (d & EV_IM);
        8'h38: m_mk = m_mk & ~d;
        default: ;
      endcase
    end
    m_fl = m_fl | ({10'h0, he, 16'h0} | {26'h0, fe});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 6'h0, 6'h0);
  endtask

  task automatic rd(input logic [7:0] a);
    step(1'b1, 1'b0, a, 32'h0, 6'h0, 6'h0);
  endtask

  task automatic rd_all();
    rd(8'h10); rd(8'h1C); rd(8'h20); rd(8'h30);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] alist [14];
    alist = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h2C, 8'h3C, 8'h20,
              8'h24, 8'h28, 8'h30, 8'h34, 8'h38, 8'h40, 8'h00};
    m_en = 32'h0; m_st = ST_IM; m_fl = 32'h0; m_mk = EV_IM;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; full_evt = 0; half_evt = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) step(1'b0, 1'b0, 8'h0, 32'h0, 6'h0, 6'h0);

    // R1 reset values through the read port
    cur_tag = "R1"; rd_all();

    // R2 companion and unused offsets read zero
    cur_tag = "R2";
    rd(8'h14); rd(8'h28); rd(8'h3C); rd(8'h40);

    // R3 set companion, zeros leave bits alone
    cur_tag = "R3";
    wr(8'h14, 32'h0000_8005); rd(8'h10);
    wr(8'h14, 32'h0000_0000); rd(8'h10);
    wr(8'h14, 32'h0000_0002); rd(8'h10);

    // R4 clear companion
    cur_tag = "R4";
    wr(8'h18, 32'h0000_0001); rd(8'h10);
    wr(8'h3C, 32'h0001_0004); rd(8'h1C);
    wr(8'h38, 32'h0000_0000); rd(8'h30);

    // R5 all-ones writes touch only implemented bits
    cur_tag = "R5";
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF); rd_all();
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); rd_all();

    // R6 event pulses latch; R8 irq follows unmasked flags
    cur_tag = "R6";
    step(1'b0, 1'b0, 8'h0, 32'h0, 6'h04, 6'h10); rd(8'h20);
    step(1'b1, 1'b0, 8'h20, 32'h0, 6'h00, 6'h01); rd(8'h20);
    cur_tag = "R8";
    wr(8'h34, 32'h0010_0000); rd(8'h30);
    wr(8'h34, 32'h0000_0004); wr(8'h28, 32'h0000_0004);
    wr(8'h38, 32'h0010_0004); rd(8'h20);

    // R7 clear and event on the same bit: event wins
    cur_tag = "R7";
    step(1'b1, 1'b1, 8'h28, 32'h0000_0008, 6'h08, 6'h00); rd(8'h20);
    step(1'b1, 1'b1, 8'h28, 32'h0002_0000, 6'h00, 6'h02); rd(8'h20);

    // R10 deselected writes change nothing
    cur_tag = "R10";
    step(1'b0, 1'b1, 8'h24, 32'hFFFF_FFFF, 6'h0, 6'h0);
    step(1'b0, 1'b1, 8'h38, 32'hFFFF_FFFF, 6'h0, 6'h0);
    step(1'b0, 1'b1, 8'h18, 32'hFFFF_FFFF, 6'h0, 6'h0);
    rd_all();

    // R2 mixed pseudo-random traffic
    cur_tag = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [5:0] fe, he;
      fe = ($urandom % 5 == 0) ? 6'($urandom) : 6'h0;
      he = ($urandom % 5 == 0) ? 6'($urandom) : 6'h0;
      step(1'($urandom % 4 != 0), 1'($urandom), alist[$urandom % 14], $urandom, fe, he);
    end
    rd_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule